// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit base-address register that places the memory-mapped PCIe configuration window of a host bridge. Host software writes the register through the bridge's configuration space with byte enables. The block turns the stored value into a decoded window, made of an enable, a base address and a size, and a combinational hit flag for an incoming physical address. It also works out the bounds of the 32-bit PCI memory hole. That hole starts right after the window and ends just below the interrupt-controller region at the top of the 32-bit space.

The valid base bits depend on the window length. A shorter window lets one or two more low address bits take part in the base. The hole start follows the window end when the window is on. When the window is off, the hole start falls back to a fixed value that leaves room for the largest window at the default base. A reserved length code raises an error flag and keeps the window closed.

Top module: `cfgwin_decoder`

## Requirements
- R1: After a synchronous reset the stored register value is 0x0000_0000_B000_0000. The decoded outputs then read: window off, base 0, size 0, error 0, hole start 0xC000_0000, hole end 0xFEBF_FFFF.
- R2: Bit 0 of the register enables the window. While it is 0, `win_en` is 0, base and size read 0, and `hit` is never asserted.
- R3: Bits 2:1 select the window length. 00 selects 256 MiB, 01 selects 128 MiB and 10 selects 64 MiB.
- R4: The base is the register value ANDed with a mask. At 256 MiB the mask covers bits ADDR_W-1:28. At 128 MiB it also covers bit 27, and at 64 MiB it covers bits 27 and 26.
- R5: While the window is on, the hole start is the low 32 bits of base plus size.
- R6: While the window is off, or the length code is reserved, the hole start is 0xC000_0000. This is the default base plus 256 MiB.
- R7: The hole end is always 0xFEBF_FFFF.
- R8: Length code 11 is reserved. It sets `cfg_err` to 1 and holds the window off even when bit 0 is set.
- R9: The register spans two dwords at byte offsets REG_OFS (bits 31:0) and REG_OFS+4 (bits 63:32), in little-endian order. Only the bytes whose `wr_be` bit is set are changed.
- R10: A write to any other dword, or a write with `wr_be` of 0, leaves every output unchanged.
- R11: A write sampled at clock edge k shows up on the decoded outputs after edge k+1. The outputs still hold their old values between those two edges.
- R12: `hit` is combinational. It is 1 exactly when the window is on and base <= `hit_addr` < base + size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_ofs | input | OFS_W | Byte offset of the written dword |
| wr_be | input | 4 | Byte enables of the written dword |
| wr_data | input | 32 | Write data |
| hit_addr | input | ADDR_W | Address to test against the window |
| win_en | output | 1 | Window decoded and active |
| win_base | output | ADDR_W | Window base address |
| win_size | output | ADDR_W | Window size in bytes |
| cfg_err | output | 1 | Reserved length code selected |
| hole_start | output | 32 | First byte of the 32-bit PCI hole |
| hole_end | output | 32 | Last byte of the 32-bit PCI hole |
| hit | output | 1 | `hit_addr` falls inside the window |

## Verification
The hardest case is stale base bits. Low address bits written while a short window was selected must drop out of the base once a longer length is chosen. To reach it, the stimulus first selects 64 MiB with bits 27 and 26 set. It then rewrites only byte 0 to choose 256 MiB, so the upper bytes keep their old contents while the mask narrows. A similar partial write to byte 0 of the upper dword moves the window above 4 GiB. This checks that the hole start wraps to the low 32 bits and that the register does not lose its high half.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic [1:0] {
    LEN_256 = 2'b00,
    LEN_128 = 2'b01,
    LEN_64  = 2'b10,
    LEN_RSV = 2'b11
  } win_len_e;

  localparam int EN_BIT  = 0;
  localparam int LEN_LSB = 1;
  localparam int LEN_MSB = 2;
endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
  parameter int          OFS_W    = 8,
  parameter logic [7:0]  REG_OFS  = 8'h60,
  parameter logic [31:0] DEF_BASE = 32'hB000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  output logic [63:0]      reg_q,
  output logic             recalc
);
  localparam logic [OFS_W-3:0] LO_IDX = REG_OFS[OFS_W-1:2];
  localparam logic [OFS_W-3:0] HI_IDX = LO_IDX + 1'b1;

  logic sel_lo, sel_hi, touch;

  assign sel_lo = wr_en && (wr_ofs[OFS_W-1:2] == LO_IDX);
  assign sel_hi = wr_en && (wr_ofs[OFS_W-1:2] == HI_IDX);
  assign touch  = (sel_lo || sel_hi) && (wr_be != 4'b0000);

  for (genvar b = 0; b < 4; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q[8*b +: 8]      <= DEF_BASE[8*b +: 8];
        reg_q[32 + 8*b +: 8] <= 8'h00;
      end else begin
        if (sel_lo && wr_be[b]) reg_q[8*b +: 8]      <= wr_data[8*b +: 8];
        if (sel_hi && wr_be[b]) reg_q[32 + 8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) recalc <= 1'b0;
    else     recalc <= touch;
  end
endmodule

// File: rtl/cfgwin_lendec.sv
module cfgwin_lendec
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int BASE_LSB = 28
) (
  input  logic [63:0]       reg_q,
  output logic              dec_en,
  output logic              dec_err,
  output logic [ADDR_W-1:0] dec_base,
  output logic [ADDR_W-1:0] dec_size
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  win_len_e          code;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] sz;

  always_comb begin
    code    = win_len_e'(reg_q[LEN_MSB:LEN_LSB]);
    mask    = '0;
    mask[ADDR_W-1:BASE_LSB] = '1;
    sz      = '0;
    dec_err = 1'b0;
    case (code)
      LEN_256: sz = ONE << BASE_LSB;
      LEN_128: begin
        mask[BASE_LSB-1] = 1'b1;
        sz = ONE << (BASE_LSB - 1);
      end
      LEN_64: begin
        mask[BASE_LSB-1] = 1'b1;
        mask[BASE_LSB-2] = 1'b1;
        sz = ONE << (BASE_LSB - 2);
      end
      default: dec_err = 1'b1;
    endcase
    dec_en   = reg_q[EN_BIT] && !dec_err;
    dec_base = dec_en ? (reg_q[ADDR_W-1:0] & mask) : '0;
    dec_size = dec_en ? sz : '0;
  end
endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit #(
  parameter int ADDR_W = 36
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W:0] lim;
  assign lim = {1'b0, base} + {1'b0, size};
  assign hit = en && (addr >= base) && ({1'b0, addr} < lim);
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int          ADDR_W   = 36,
  parameter int          OFS_W    = 8,
  parameter logic [7:0]  REG_OFS  = 8'h60,
  parameter int          BASE_LSB = 28,
  parameter logic [31:0] DEF_BASE = 32'hB000_0000,
  parameter logic [31:0] APIC_LOW = 32'hFEC0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_size,
  output logic              cfg_err,
  output logic [31:0]       hole_start,
  output logic [31:0]       hole_end
  ,output logic             hit
);
  localparam logic [31:0] OFF_START = DEF_BASE + (32'd1 << BASE_LSB);
  localparam logic [31:0] HOLE_LAST = APIC_LOW - 32'd1;

  logic [63:0]       reg_q;
  logic              recalc;
  logic              d_en, d_err;
  logic [ADDR_W-1:0] d_base, d_size, d_end;

  cfgwin_regs #(.OFS_W(OFS_W), .REG_OFS(REG_OFS), .DEF_BASE(DEF_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_be(wr_be),
    .wr_data(wr_data), .reg_q(reg_q), .recalc(recalc)
  );

  cfgwin_lendec #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_dec (
    .reg_q(reg_q), .dec_en(d_en), .dec_err(d_err),
    .dec_base(d_base), .dec_size(d_size)
  );

  assign d_end = d_base + d_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en     <= 1'b0;
      win_base   <= '0;
      win_size   <= '0;
      cfg_err    <= 1'b0;
      hole_start <= OFF_START;
      hole_end   <= HOLE_LAST;
    end else if (recalc) begin
      win_en     <= d_en;
      win_base   <= d_base;
      win_size   <= d_size;
      cfg_err    <= d_err;
      hole_start <= d_en ? d_end[31:0] : OFF_START;
      hole_end   <= HOLE_LAST;
    end
  end

  cfgwin_hit #(.ADDR_W(ADDR_W)) u_hit (
    .en(win_en), .base(win_base), .size(win_size), .addr(hit_addr), .hit(hit)
  );
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_size,
  input logic              cfg_err,
  input logic [31:0]       hole_start,
  input logic              hit
);
  logic [ADDR_W-1:0] sum;
  assign sum = win_base + win_size;

  // R2
  off_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !win_en |-> !hit);
  // R8
  rsv_closed_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !win_en);
  // R3
  size_legal_chk: assert property (@(posedge clk) disable iff (rst)
    win_en |-> ($onehot(win_size) && (win_size[28:26] != 3'b000)));
  // R4
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    win_en |-> ((win_base & (win_size - 1'b1)) == '0));
  // R5
  hole_follow_chk: assert property (@(posedge clk) disable iff (rst)
    win_en |-> (hole_start == sum[31:0]));
  // R10
  quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(wr_en)) |=> ($stable(win_base) && $stable(win_en)));
endmodule

bind cfgwin_decoder cfgwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .win_en(win_en), .win_base(win_base),
  .win_size(win_size), .cfg_err(cfg_err), .hole_start(hole_start), .hit(hit)
);

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;
  localparam int AW = 36;

  typedef struct {
    string       tag;
    logic        en;
    logic        err;
    logic [AW-1:0] base;
    logic [AW-1:0] size;
    logic [31:0] hs;
  } exp_t;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [7:0] wr_ofs = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [AW-1:0] hit_addr = 0;
  logic win_en, cfg_err, hit;
  logic [AW-1:0] win_base, win_size;
  logic [31:0] hole_start, hole_end;

  int checks = 0, fails = 0;
  logic [63:0] model = 64'hB000_0000;
  exp_t q[$];
  bit done = 0;

  always #4 clk = ~clk;

  cfgwin_decoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_be(wr_be),
    .wr_data(wr_data), .hit_addr(hit_addr), .win_en(win_en),
    .win_base(win_base), .win_size(win_size), .cfg_err(cfg_err),
    .hole_start(hole_start), .hole_end(hole_end), .hit(hit)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model_exp(string tag, logic [63:0] r);
    exp_t e;
    logic [AW-1:0] raw;
    logic [AW-1:0] sum;
    e.tag = tag;
    raw = r[AW-1:0];
    e.err = (r[2:1] == 2'b11);
    e.en = r[0] && !e.err;
    case (r[2:1])
      2'b00: begin e.size = 36'h1000_0000; e.base = {raw[AW-1:28], 28'h0}; end
      2'b01: begin e.size = 36'h0800_0000; e.base = {raw[AW-1:27], 27'h0}; end
      2'b10: begin e.size = 36'h0400_0000; e.base = {raw[AW-1:26], 26'h0}; end
      default: begin e.size = 0; e.base = 0; end
    endcase
    if (!e.en) begin e.size = 0; e.base = 0; end
    sum = e.base + e.size;
    e.hs = e.en ? sum[31:0] : 32'hC000_0000;
    return e;
  endfunction

  task automatic write(string tag, logic [7:0] ofs, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_ofs = ofs; wr_be = be; wr_data = d;
    if (ofs[7:2] == 6'h18) for (int b = 0; b < 4; b++) if (be[b]) model[8*b +: 8] = d[8*b +: 8];
    if (ofs[7:2] == 6'h19) for (int b = 0; b < 4; b++) if (be[b]) model[32+8*b +: 8] = d[8*b +: 8];
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_be = 0;
    @(posedge clk);
    q.push_back(model_exp(tag, model));
    wait (q.size() == 0);
  endtask

  task automatic probe(string tag, logic [AW-1:0] a, logic e);
    @(negedge clk);
    hit_addr = a;
    #1;
    chk(tag, {63'b0, hit}, {63'b0, e});
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " en"}, {63'b0, win_en}, {63'b0, e.en});
        chk({e.tag, " err"}, {63'b0, cfg_err}, {63'b0, e.err});
        chk({e.tag, " base"}, {28'b0, win_base}, {28'b0, e.base});
        chk({e.tag, " size"}, {28'b0, win_size}, {28'b0, e.size});
        chk({e.tag, " hole_start"}, {32'b0, hole_start}, {32'b0, e.hs});
        chk("R7 hole_end", {32'b0, hole_end}, 64'hFEBF_FFFF);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    chk("R1 en", {63'b0, win_en}, 0);
    chk("R1 base", {28'b0, win_base}, 0);
    chk("R1 size", {28'b0, win_size}, 0);
    chk("R1 err", {63'b0, cfg_err}, 0);
    chk("R1 hole_start", {32'b0, hole_start}, 64'hC000_0000);
    chk("R7 hole_end", {32'b0, hole_end}, 64'hFEBF_FFFF);
    probe("R2 hit while off", 36'h0_B000_0000, 0);

    // R11 latency: old value between edges k and k+1
    @(negedge clk);
    wr_en = 1; wr_ofs = 8'h60; wr_be = 4'hF; wr_data = 32'hB000_0001;
    model[31:0] = 32'hB000_0001;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_be = 0;
    chk("R11 still old", {63'b0, win_en}, 0);
    @(posedge clk);
    q.push_back(model_exp("R11 R3 R5 256M", model));
    wait (q.size() == 0);

    probe("R12 hit low edge", 36'h0_B000_0000, 1);
    probe("R12 hit top", 36'h0_BFFF_FFFF, 1);
    probe("R12 miss above", 36'h0_C000_0000, 0);
    probe("R12 miss below", 36'h0_AFFF_FFFF, 0);

    write("R3 R4 128M", 8'h60, 4'hF, 32'hE000_0003);
    probe("R12 hit 128M top", 36'h0_E7FF_FFFF, 1);
    probe("R12 miss 128M end", 36'h0_E800_0000, 0);
    write("R3 R4 64M", 8'h60, 4'hF, 32'hEC00_0005);
    probe("R12 hit 64M", 36'h0_EC00_0000, 1);
    write("R4 R9 mask narrows", 8'h60, 4'h1, 32'h0000_0001);
    write("R8 reserved", 8'h60, 4'h1, 32'h0000_0007);
    probe("R8 R2 no hit reserved", 36'h0_E000_0000, 0);
    write("R9 high byte", 8'h64, 4'h1, 32'hFFFF_FF01);
    write("R9 R5 above 4G", 8'h60, 4'h1, 32'h0000_0001);
    probe("R12 hit above 4G", 36'h1_E000_0000, 1);
    write("R10 other dword", 8'h68, 4'hF, 32'h0000_0006);
    write("R10 zero be", 8'h60, 4'h0, 32'h0000_0000);
    write("R2 R6 disable", 8'h60, 4'h1, 32'h0000_0000);
    probe("R2 no hit off", 36'h1_E000_0000, 0);

    // reset mid-run
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    model = 64'hB000_0000;
    chk("R1 re-reset hole_start", {32'b0, hole_start}, 64'hC000_0000);
    chk("R1 re-reset en", {63'b0, win_en}, 0);
    write("R1 R9 reg reloaded", 8'h60, 4'h1, 32'h0000_0001);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule